// File: doc/BRIEF.md
# Single-Strobe Parallel Word Transfer

This block pairs a sending controller and a receiving controller that move one parallel word at a time across a shared data bus. The only timing line between them is a single strobe wire, and there is no acknowledgement path. Both controllers run on the same local clock. The strobe still reaches the receiving logic through a two-flop synchroniser, and every decision about the strobe uses edges of that synchronised copy.

The initiator is selected with `init_by_dst`.

- **Sender-initiated (`init_by_dst` = 0).** On `src_go` the sender puts the word on the bus and waits SETUP cycles. It then raises the strobe for WIDTH cycles and keeps the word on the bus for HOLD cycles after the strobe drops. The receiver takes the word that was on the bus when the strobe fell.
- **Receiver-initiated (`init_by_dst` = 1).** On `dst_fetch` the receiver raises the strobe as a request. The sender sees the synchronised rising edge and answers by driving `src_word`. The receiver keeps the strobe up long enough for the answer to settle and then drops it, which captures the word. The sender releases the bus HOLD cycles after it sees the strobe fall.

In both modes a completed capture is announced by a one-cycle `rx_valid` pulse. The captured word then stays on `rx_word` until the next capture.

Top module: `strobe_xfer_top`

## Requirements
- R1: While `rst_n` is low, `bus_strobe`, `bus_drive`, `busy` and `rx_valid` are 0, and `bus_data` and `rx_word` are all zeros.
- R2: With `init_by_dst` = 0, a clock edge that sees `src_go` = 1 and `busy` = 0 starts a transfer of `src_word`. From the next cycle `bus_drive` = 1 and `bus_data` equals that word. `bus_strobe` rises SETUP cycles after `bus_drive` rises.
- R3: In sender-initiated mode `bus_strobe` stays high for exactly WIDTH cycles. `bus_drive` and the word remain for HOLD more cycles after it falls, and then `bus_drive` = 0 and `bus_data` = 0.
- R4: Every strobe fall produces `rx_valid` = 1 for exactly one cycle, three cycles after the first low cycle of `bus_strobe` (two synchroniser stages plus the edge register). `rx_word` then equals the bus word of that first low cycle, and it holds that value until the next capture.
- R5: With `init_by_dst` = 1, an edge that sees `dst_fetch` = 1 and `busy` = 0 raises `bus_strobe` from the next cycle. The strobe stays high for SETUP+WIDTH+3 cycles.
- R6: In receiver-initiated mode the sender drives `src_word`, sampled three cycles after the request edge, starting from that cycle. It keeps driving until HOLD+3 cycles after the strobe has fallen.
- R7: `busy` is 1 from the cycle after a start until both controllers are idle. Any `src_go` or `dst_fetch` seen while `busy` = 1 is ignored: bus, strobe and captured word are unaffected.
- R8: `src_go` is ignored while `init_by_dst` = 1, and `dst_fetch` is ignored while `init_by_dst` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_by_dst | input | 1 | 0: sender initiates, 1: receiver initiates |
| src_go | input | 1 | Start a sender-initiated transfer |
| src_word | input | W | Word offered by the sender |
| dst_fetch | input | 1 | Start a receiver-initiated transfer |
| bus_data | output | W | Shared data bus (zero when undriven) |
| bus_drive | output | 1 | Sender is driving the bus |
| bus_strobe | output | 1 | The single strobe line |
| busy | output | 1 | A transfer is in progress |
| rx_word | output | W | Last captured word |
| rx_valid | output | 1 | One-cycle pulse on each capture |

## Verification
A sender counter that is off by one shows up at once as a strobe edge or a bus release one cycle early or late. A wrong state encoding shows as a strobe or drive level that disagrees with the cycle-exact reference in the very cycle after the edge concerned. Faults in the synchroniser or the data delay line appear three cycles after a strobe fall, as a misplaced `rx_valid` pulse or a `rx_word` taken from the wrong cycle. A broken busy interlock shows as a second transfer whose drive or strobe starts where the reference expects none.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int SYNC_STAGES = 2;
    localparam int RESP_LAT    = SYNC_STAGES + 1;

    typedef enum logic [2:0] {
        SRC_IDLE, SRC_SETUP, SRC_PULSE, SRC_HOLD, SRC_ANS
    } src_state_e;

    typedef enum logic [1:0] {
        DST_IDLE, DST_REQ, DST_WAIT
    } dst_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = line_i;
        for (int i = 1; i <= STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/src_ctrl.sv
module src_ctrl
    import xfer_pkg::*;
#(
    parameter int W     = 8,
    parameter int SETUP = 2,
    parameter int WIDTH = 3,
    parameter int HOLD  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dst_mode,
    input  logic         go_i,
    input  logic [W-1:0] word_i,
    input  logic         peer_busy,
    input  logic         rise_i,
    input  logic         fall_i,
    output logic         drv_o,
    output logic         stb_o,
    output logic [W-1:0] data_o
);
    localparam int CMAX = max3(SETUP, WIDTH, HOLD);
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        src_state_e    st;
        logic [CW-1:0] cnt;
        logic [W-1:0]  word;
    } src_reg_t;

    src_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            SRC_IDLE: begin
                if (rise_i && peer_busy) begin
                    r_d.st   = SRC_ANS;
                    r_d.word = word_i;
                end else if (go_i && !dst_mode && !peer_busy) begin
                    r_d.st   = SRC_SETUP;
                    r_d.cnt  = CW'(SETUP - 1);
                    r_d.word = word_i;
                end
            end
            SRC_SETUP: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = SRC_PULSE;
                    r_d.cnt = CW'(WIDTH - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            SRC_PULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = SRC_HOLD;
                    r_d.cnt = CW'(HOLD - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            SRC_ANS: begin
                if (fall_i) begin
                    r_d.st  = SRC_HOLD;
                    r_d.cnt = CW'(HOLD - 1);
                end
            end
            SRC_HOLD: begin
                if (r_q.cnt == '0) r_d.st = SRC_IDLE;
                else               r_d.cnt = r_q.cnt - CW'(1);
            end
            default: r_d.st = SRC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: SRC_IDLE, cnt: '0, word: '0};
        else        r_q <= r_d;
    end

    assign drv_o  = (r_q.st != SRC_IDLE);
    assign stb_o  = (r_q.st == SRC_PULSE);
    assign data_o = drv_o ? r_q.word : '0;

    // R2
    setup_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_o) |-> $past(drv_o));

    // R3
    hold_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_o) |-> drv_o);
endmodule

// File: rtl/dst_ctrl.sv
module dst_ctrl
    import xfer_pkg::*;
#(
    parameter int W     = 8,
    parameter int SETUP = 2,
    parameter int WIDTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dst_mode,
    input  logic         fetch_i,
    input  logic         peer_busy,
    input  logic         fall_i,
    input  logic [W-1:0] bus_i,
    output logic         stb_o,
    output logic         busy_o,
    output logic [W-1:0] rx_word_o,
    output logic         rx_valid_o
);
    localparam int REQ_LEN = SETUP + WIDTH + RESP_LAT;
    localparam int CW      = $clog2(REQ_LEN + 1);

    typedef struct packed {
        dst_state_e                       st;
        logic [CW-1:0]                    cnt;
        logic [SYNC_STAGES-1:0][W-1:0]    pipe;
        logic [W-1:0]                     rx_word;
        logic                             rx_valid;
    } dst_reg_t;

    dst_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.pipe[0] = bus_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            r_d.pipe[i] = r_q.pipe[i-1];
        end
        r_d.rx_valid = fall_i;
        if (fall_i) r_d.rx_word = r_q.pipe[SYNC_STAGES-1];
        case (r_q.st)
            DST_IDLE: begin
                if (fetch_i && dst_mode && !peer_busy) begin
                    r_d.st  = DST_REQ;
                    r_d.cnt = CW'(REQ_LEN - 1);
                end
            end
            DST_REQ: begin
                if (r_q.cnt == '0) r_d.st = DST_WAIT;
                else               r_d.cnt = r_q.cnt - CW'(1);
            end
            DST_WAIT: begin
                if (fall_i) r_d.st = DST_IDLE;
            end
            default: r_d.st = DST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stb_o      = (r_q.st == DST_REQ);
    assign busy_o     = (r_q.st != DST_IDLE);
    assign rx_word_o  = r_q.rx_word;
    assign rx_valid_o = r_q.rx_valid;

    // R4
    pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/strobe_xfer_top.sv
module strobe_xfer_top
    import xfer_pkg::*;
#(
    parameter int W     = 8,
    parameter int SETUP = 2,
    parameter int WIDTH = 3,
    parameter int HOLD  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_by_dst,
    input  logic         src_go,
    input  logic [W-1:0] src_word,
    input  logic         dst_fetch,
    output logic [W-1:0] bus_data,
    output logic         bus_drive,
    output logic         bus_strobe,
    output logic         busy,
    output logic [W-1:0] rx_word,
    output logic         rx_valid
);
    logic src_stb, dst_stb, dst_busy, stb_rise, stb_fall;

    assign bus_strobe = src_stb | dst_stb;
    assign busy       = bus_drive | dst_busy;

    strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .line_i(bus_strobe),
        .rise_o(stb_rise), .fall_o(stb_fall)
    );

    src_ctrl #(.W(W), .SETUP(SETUP), .WIDTH(WIDTH), .HOLD(HOLD)) src_i (
        .clk(clk), .rst_n(rst_n), .dst_mode(init_by_dst), .go_i(src_go),
        .word_i(src_word), .peer_busy(dst_busy), .rise_i(stb_rise),
        .fall_i(stb_fall), .drv_o(bus_drive), .stb_o(src_stb), .data_o(bus_data)
    );

    dst_ctrl #(.W(W), .SETUP(SETUP), .WIDTH(WIDTH)) dst_i (
        .clk(clk), .rst_n(rst_n), .dst_mode(init_by_dst), .fetch_i(dst_fetch),
        .peer_busy(bus_drive), .fall_i(stb_fall), .bus_i(bus_data),
        .stb_o(dst_stb), .busy_o(dst_busy), .rx_word_o(rx_word),
        .rx_valid_o(rx_valid)
    );

    // R5
    single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_stb && dst_stb));

    // R6
    answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dst_stb) |-> bus_drive);
endmodule

// File: tb/strobe_xfer_top_tb_top.sv
module strobe_xfer_top_tb_top;
    localparam int W = 8, S = 2, WD = 3, H = 1;
    localparam int L = S + WD + 3;

    logic clk = 0, rst_n = 0, mode = 0, go = 0, fetch = 0;
    logic [W-1:0] word = '0;
    logic [W-1:0] bus_data, rx_word;
    logic bus_drive, bus_strobe, busy, rx_valid;

    strobe_xfer_top #(.W(W), .SETUP(S), .WIDTH(WD), .HOLD(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .init_by_dst(mode), .src_go(go),
        .src_word(word), .dst_fetch(fetch), .bus_data(bus_data),
        .bus_drive(bus_drive), .bus_strobe(bus_strobe), .busy(busy),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    always #2 clk = ~clk;

    int vecs = 0, errs = 0, cyc = 0, t0 = 0;
    bit act = 0, mmode = 0, done = 0;
    logic [W-1:0] mword = '0, exp_rxw = '0;
    int rx_at[$];
    logic [W-1:0] rx_w[$];
    string ctx = "";

    function automatic bit m_busy(int c);
        int n = c - t0;
        if (!act) return 0;
        return mmode ? (n < L + 3 + H) : (n < S + WD + H);
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            act = 0; cyc = 0; rx_at.delete(); rx_w.delete(); exp_rxw = '0;
        end else begin
            bit b;
            b = m_busy(cyc);
            cyc++;
            if (!b && (mode ? fetch : go)) begin
                act = 1; t0 = cyc; mmode = mode;
                if (!mode) begin
                    mword = word;
                    rx_at.push_back(cyc + S + WD + 3); rx_w.push_back(word);
                end
            end
            if (act && mmode && (cyc - t0 == 3)) begin
                mword = word;
                rx_at.push_back(t0 + L + 3); rx_w.push_back(word);
            end
        end
    end

    task automatic chk(string tag, string nm, logic [31:0] a, logic [31:0] e);
        vecs++;
        if (a !== e) begin
            errs++;
            $display("FAIL %s %s %s: got %0h expected %0h (cycle %0d)", tag, ctx, nm, a, e, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk("R1", "strobe", 32'(bus_strobe), 0);
                chk("R1", "drive", 32'(bus_drive), 0);
                chk("R1", "busy", 32'(busy), 0);
                chk("R1", "rx_valid", 32'(rx_valid), 0);
                chk("R1", "bus_data", 32'(bus_data), 0);
                chk("R1", "rx_word", 32'(rx_word), 0);
            end else begin
                int n;
                bit ed, es, ev;
                n  = cyc - t0;
                ed = act && (mmode ? (n >= 3 && n < L + 3 + H) : (n < S + WD + H));
                es = act && (mmode ? (n < L) : (n >= S && n < S + WD));
                ev = (rx_at.size() > 0) && (rx_at[0] == cyc);
                if (ev) begin
                    exp_rxw = rx_w[0];
                    void'(rx_at.pop_front()); void'(rx_w.pop_front());
                end
                chk(mmode ? "R6" : "R2", "drive", 32'(bus_drive), 32'(ed));
                chk(mmode ? "R6" : "R2", "bus_data", 32'(bus_data), ed ? 32'(mword) : 0);
                chk(mmode ? "R5" : "R3", "strobe", 32'(bus_strobe), 32'(es));
                chk("R7", "busy", 32'(busy), 32'(m_busy(cyc)));
                chk("R4", "rx_valid", 32'(rx_valid), 32'(ev));
                chk("R4", "rx_word", 32'(rx_word), 32'(exp_rxw));
            end
        end
    end

    task automatic tick(input bit g, input bit f, input bit m, input logic [W-1:0] wv, input int n);
        for (int i = 0; i < n; i++) begin
            go = g; fetch = f; mode = m; word = wv + W'(i);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        ctx = "R2 single";   tick(1, 0, 0, 8'hA5, 1); tick(0, 0, 0, 8'h00, 15);
        ctx = "R7 held go";  tick(1, 0, 0, 8'h10, 40); tick(0, 0, 0, 0, 12);
        ctx = "R5 single";   tick(0, 1, 1, 8'h3C, 1); tick(0, 0, 1, 8'h70, 25);
        ctx = "R7 held fetch"; tick(0, 1, 1, 8'h80, 60); tick(0, 0, 1, 0, 20);
        ctx = "R8 fetch in mode0"; tick(0, 1, 0, 8'h55, 15);
        ctx = "R8 go in mode1";    tick(1, 0, 1, 8'h66, 15);
        ctx = "R8 idle";           tick(0, 0, 0, 0, 6);
        ctx = "switch";      tick(1, 0, 0, 8'hC0, 1); tick(0, 0, 0, 0, S + WD + H);
                             tick(0, 1, 1, 8'hD0, 1); tick(0, 0, 1, 8'hE0, 25);
        ctx = "random";
        for (int i = 0; i < 400; i++) begin
            go = $urandom_range(0, 1); fetch = $urandom_range(0, 1);
            if ($urandom_range(0, 7) == 0) mode = ~mode;
            word = W'($urandom);
            @(negedge clk);
        end
        go = 0; fetch = 0;
        repeat (30) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1; errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule